// File: doc/BRIEF.md
# Pushbutton Power-Up Sequencing Controller

This block decides when a group of switching regulators is switched on and off. Three events can start a power-up from the off states: arrival of an external supply, a rising request on the host power-on input, and a press of the pushbutton. A supply arrival or a host request first waits a settling interval. A button press starts the power-up at once. The block then releases the open-drain wake line and opens a fixed power-up window. At the end of that window the host must be holding its power-on input high. If it is, the controller stays on. If it is not, or if the host drops the input later, every regulator is switched off in the same cycle.

Releasing wake turns the regulators on one after another, lowest index first, with a programmable tick gap between them. A power-good flag qualifies that every enabled regulator has reported in-regulation for an unbroken interval. A permission output tells the serial-bus register logic when it may switch the auxiliary linear regulators and the backlight.

When the block leaves reset with no battery, it takes a separate path. It holds in a power-down state for one interval, then parks in the hard-reset state, and from there only the pushbutton can start it. Every interval is counted in `tick_ms` pulses and set by a parameter.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: On the first clock after reset release the state code is 0 (off) and wake, aux permission, regulator enables and power-good are all low. On the next clock the state becomes 0 if `bat_ok` was high in that first cycle, or 2 (power-down wait) if it was low.
- R2: State 2 moves to state 1 (hard reset) once `PDN_T` ticks have been counted in it. In states 0 and 1 with `bat_ok` low, edges on `ext_pwr` and `host_on` are ignored, so the state code stays put.
- R3: A rising edge of `ext_pwr` in state 0 or 1 with `bat_ok` high enters state 3 (settling). After `SETTLE_EXT_T` ticks the block enters state 5 (powered-up by supply or host).
- R4: A rising edge of `host_on` in state 0 or 1 with `bat_ok` high enters state 3. After `SETTLE_HOST_T` ticks the block enters state 5.
- R5: A rising edge of `pbtn` in state 0 or 1 enters state 4 (powered-up by button) on the next clock, whether or not a battery is present. When several triggers arrive in the same cycle, the button wins over the supply, and the supply wins over the host.
- R6: In states 4 and 5, the window closes after `PUP_T` ticks. The next state is 6 (on) if `host_on` is high in that cycle, and 0 otherwise.
- R7: In state 6, a low `host_on` returns the block to state 0 on the next clock.
- R8: `wake_rel` and `aux_perm` are high exactly while the state is 4, 5 or 6.
- R9: `reg_en` is a thermometer code. Bit 0 sets on the clock after wake is released. Each higher bit sets `STEP_T` ticks after the bit below it.
- R10: One clock after wake goes low, all bits of `reg_en` clear together.
- R11: `pgood` rises only after at least one regulator is enabled and every enabled regulator has had its `reg_ok` bit high for `PG_T` consecutive ticks. It falls in the same cycle that any enabled regulator's `reg_ok` bit drops, and the qualification count then restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle timebase pulse; all intervals count these |
| bat_ok | input | 1 | Battery present |
| ext_pwr | input | 1 | External supply present |
| host_on | input | 1 | Host power-on request level |
| pbtn | input | 1 | Pushbutton pressed level; rising edge is a press |
| reg_ok | input | N_REG | Per-regulator in-regulation flags |
| wake_rel | output | 1 | 1 = wake line released (high impedance), 0 = driven low |
| reg_en | output | N_REG | Per-regulator enables, thermometer coded |
| pgood | output | 1 | All enabled regulators qualified in regulation |
| state_code | output | 3 | Controller state code |
| aux_perm | output | 1 | Auxiliary regulator control permitted |

## Verification
Two functions can land in the same cycle: the button press and a supply or host edge can each start a power-up. The bench raises `pbtn` and `ext_pwr` on the same clock from the off state and checks that the state code reads 4, not 3. The random phase keeps producing these collisions, together with `reg_ok` drops that coincide with the end of power-good qualification. Every cycle is compared against a bench model, which confirms that the priority order and the same-cycle loss of power-good hold throughout.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_POFF = 3'd0,
    ST_HR   = 3'd1,
    ST_PDN2 = 3'd2,
    ST_ARM  = 3'd3,
    ST_PUP1 = 3'd4,
    ST_PUP2 = 3'd5,
    ST_PON  = 3'd6
  } pseq_state_e;

  function automatic logic is_up(pseq_state_e s);
    return (s == ST_PUP1) || (s == ST_PUP2) || (s == ST_PON);
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int SETTLE_EXT_T  = 100,
  parameter int SETTLE_HOST_T = 50,
  parameter int PUP_T         = 5000,
  parameter int PDN_T         = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        bat_ok,
  input  logic        ext_pwr,
  input  logic        host_on,
  input  logic        pbtn,
  output pseq_state_e state_q,
  output logic        wake_rel,
  output logic        aux_perm
);

  localparam int TMAX = imax(imax(SETTLE_EXT_T, SETTLE_HOST_T), imax(PUP_T, PDN_T));
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] LIM_EXT  = TW'(SETTLE_EXT_T - 1);
  localparam logic [TW-1:0] LIM_HOST = TW'(SETTLE_HOST_T - 1);
  localparam logic [TW-1:0] LIM_PUP  = TW'(PUP_T - 1);
  localparam logic [TW-1:0] LIM_PDN  = TW'(PDN_T - 1);

  pseq_state_e   state_d;
  logic          boot_q, src_host_q, src_host_d;
  logic          ext_d, host_d, btn_d;
  logic [TW-1:0] tmr_q, tmr_d, lim;
  logic          timed, expired;
  logic          ext_rise, host_rise, btn_rise;

  always_comb begin
    ext_rise  = ext_pwr & ~ext_d;
    host_rise = host_on & ~host_d;
    btn_rise  = pbtn & ~btn_d;

    timed = 1'b1;
    unique case (state_q)
      ST_PDN2:          lim = LIM_PDN;
      ST_ARM:           lim = src_host_q ? LIM_HOST : LIM_EXT;
      ST_PUP1, ST_PUP2: lim = LIM_PUP;
      default: begin
        lim   = '0;
        timed = 1'b0;
      end
    endcase
    expired = timed & tick & (tmr_q == lim);

    state_d    = state_q;
    src_host_d = src_host_q;
    if (boot_q) begin
      state_d = bat_ok ? ST_POFF : ST_PDN2;
    end else begin
      unique case (state_q)
        ST_POFF, ST_HR: begin
          if (btn_rise) begin
            state_d = ST_PUP1;
          end else if (bat_ok && ext_rise) begin
            state_d    = ST_ARM;
            src_host_d = 1'b0;
          end else if (bat_ok && host_rise) begin
            state_d    = ST_ARM;
            src_host_d = 1'b1;
          end
        end
        ST_PDN2:          if (expired) state_d = ST_HR;
        ST_ARM:           if (expired) state_d = ST_PUP2;
        ST_PUP1, ST_PUP2: if (expired) state_d = host_on ? ST_PON : ST_POFF;
        ST_PON:           if (!host_on) state_d = ST_POFF;
        default:          state_d = ST_POFF;
      endcase
    end

    if (state_d != state_q) begin
      tmr_d = '0;
    end else if (timed && tick) begin
      tmr_d = tmr_q + TW'(1);
    end else begin
      tmr_d = tmr_q;
    end

    wake_rel = is_up(state_q);
    aux_perm = is_up(state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_POFF;
      boot_q     <= 1'b1;
      src_host_q <= 1'b0;
      tmr_q      <= '0;
      ext_d      <= 1'b0;
      host_d     <= 1'b0;
      btn_d      <= 1'b0;
    end else begin
      state_q    <= state_d;
      boot_q     <= 1'b0;
      src_host_q <= src_host_d;
      tmr_q      <= tmr_d;
      ext_d      <= ext_pwr;
      host_d     <= host_on;
      btn_d      <= pbtn;
    end
  end

  AST_PDN2_TO_HR: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(state_q) == ST_PDN2) && (state_q != ST_PDN2)) |-> (state_q == ST_HR)); // R2

  AST_NOBAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(state_q) == ST_POFF) || ($past(state_q) == ST_HR)) && !$past(bat_ok)
      && !$past(pbtn) && !$past(boot_q)) |-> (state_q == $past(state_q))); // R2

  AST_ARM_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(state_q) == ST_ARM) && (state_q != ST_ARM)) |-> (state_q == ST_PUP2)); // R3

  AST_PON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_PON) && ($past(state_q) != ST_PON)) |-> $past(host_on)); // R6

endmodule

// File: rtl/pwr_seq_ramp.sv
module pwr_seq_ramp #(
  parameter int N_REG  = 3,
  parameter int STEP_T = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wake,
  output logic [N_REG-1:0] en_q
);

  localparam int SW = (STEP_T > 1) ? $clog2(STEP_T) : 1;
  localparam logic [SW-1:0] STEP_LIM = SW'(STEP_T - 1);

  logic [N_REG-1:0] en_d;
  logic [SW-1:0]    stp_q, stp_d;

  always_comb begin
    en_d  = en_q;
    stp_d = stp_q;
    if (!wake) begin
      en_d  = '0;
      stp_d = '0;
    end else if (!en_q[0]) begin
      en_d[0] = 1'b1;
      stp_d   = '0;
    end else if (!en_q[N_REG-1] && tick) begin
      if (stp_q == STEP_LIM) begin
        en_d  = (en_q << 1) | {{(N_REG-1){1'b0}}, 1'b1};
        stp_d = '0;
      end else begin
        stp_d = stp_q + SW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      stp_q <= '0;
    end else begin
      en_q  <= en_d;
      stp_q <= stp_d;
    end
  end

  AST_EN_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q != '0) |-> ($countones(en_q) <= $countones($past(en_q)) + 1)); // R9

  AST_EN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !wake |=> (en_q == '0)); // R10

endmodule

// File: rtl/pwr_seq_pgood.sv
module pwr_seq_pgood #(
  parameter int N_REG = 3,
  parameter int PG_T  = 230
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [N_REG-1:0] reg_en,
  input  logic [N_REG-1:0] reg_ok,
  output logic             pgood
);

  localparam int CW = $clog2(PG_T + 1);
  localparam logic [CW-1:0] PG_LIM = CW'(PG_T - 1);

  logic [N_REG-1:0] lane_fine;
  logic             all_ok;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             qual_q, qual_d;

  for (genvar g = 0; g < N_REG; g++) begin : g_lane
    assign lane_fine[g] = reg_ok[g] | ~reg_en[g];
  end

  always_comb begin
    all_ok = (|reg_en) & (&lane_fine);
    cnt_d  = cnt_q;
    qual_d = qual_q;
    if (!all_ok) begin
      cnt_d  = '0;
      qual_d = 1'b0;
    end else if (!qual_q && tick) begin
      if (cnt_q == PG_LIM) qual_d = 1'b1;
      else                 cnt_d  = cnt_q + CW'(1);
    end
    pgood = qual_q & all_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      qual_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      qual_q <= qual_d;
    end
  end

  AST_PG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> (|reg_en)); // R11

  AST_PG_QUAL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qual_q) |-> ($past(all_ok) && $past(tick))); // R11

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int N_REG         = 3,
  parameter int SETTLE_EXT_T  = 100,
  parameter int SETTLE_HOST_T = 50,
  parameter int PUP_T         = 5000,
  parameter int PG_T          = 230,
  parameter int PDN_T         = 1000,
  parameter int STEP_T        = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_ms,
  input  logic             bat_ok,
  input  logic             ext_pwr,
  input  logic             host_on,
  input  logic             pbtn,
  input  logic [N_REG-1:0] reg_ok,
  output logic             wake_rel,
  output logic [N_REG-1:0] reg_en,
  output logic             pgood,
  output logic [2:0]       state_code,
  output logic             aux_perm
);

  pseq_state_e st;

  pwr_seq_fsm #(
    .SETTLE_EXT_T (SETTLE_EXT_T),
    .SETTLE_HOST_T(SETTLE_HOST_T),
    .PUP_T        (PUP_T),
    .PDN_T        (PDN_T)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_ms),
    .bat_ok  (bat_ok),
    .ext_pwr (ext_pwr),
    .host_on (host_on),
    .pbtn    (pbtn),
    .state_q (st),
    .wake_rel(wake_rel),
    .aux_perm(aux_perm)
  );

  pwr_seq_ramp #(
    .N_REG (N_REG),
    .STEP_T(STEP_T)
  ) u_ramp (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_ms),
    .wake (wake_rel),
    .en_q (reg_en)
  );

  pwr_seq_pgood #(
    .N_REG(N_REG),
    .PG_T (PG_T)
  ) u_pg (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_ms),
    .reg_en(reg_en),
    .reg_ok(reg_ok),
    .pgood (pgood)
  );

  assign state_code = st;

  AST_EN_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (|reg_en) |-> $past(wake_rel)); // R9

  AST_AUX_TRACKS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_perm == wake_rel) && (wake_rel == (state_code >= 3'd4))); // R8

endmodule

// File: tb/pwr_seq_ctrl_tb_top.sv
module pwr_seq_ctrl_tb_top;

  localparam int NR  = 3;
  localparam int SE  = 6;
  localparam int SH  = 4;
  localparam int PUP = 40;
  localparam int PG  = 10;
  localparam int PDN = 12;
  localparam int STP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0, bat_ok = 1'b0, ext_pwr = 1'b0, host_on = 1'b0, pbtn = 1'b0;
  logic [NR-1:0] reg_ok = '1;
  logic wake_rel, pgood, aux_perm;
  logic [NR-1:0] reg_en;
  logic [2:0] state_code;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_seq_ctrl #(
    .N_REG(NR), .SETTLE_EXT_T(SE), .SETTLE_HOST_T(SH), .PUP_T(PUP),
    .PG_T(PG), .PDN_T(PDN), .STEP_T(STP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .bat_ok(bat_ok),
    .ext_pwr(ext_pwr), .host_on(host_on), .pbtn(pbtn), .reg_ok(reg_ok),
    .wake_rel(wake_rel), .reg_en(reg_en), .pgood(pgood),
    .state_code(state_code), .aux_perm(aux_perm)
  );

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Bench reference model built from the requirements
  int m_st, m_t, m_n, m_s, m_c;
  bit m_boot, m_src, m_pe, m_ph, m_pb, m_q;

  function automatic int en_mask(int n);
    return (1 << n) - 1;
  endfunction

  function automatic bit m_allok(int n, logic [NR-1:0] ok);
    int mk = en_mask(n);
    return (n > 0) && ((int'(ok) & mk) == mk);
  endfunction

  function automatic int lim_of(int st, bit src);
    case (st)
      2: return PDN;
      3: return src ? SH : SE;
      4, 5: return PUP;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_t = 0; m_n = 0; m_s = 0; m_c = 0;
      m_boot = 1; m_src = 0; m_pe = 0; m_ph = 0; m_pb = 0; m_q = 0;
    end else begin
      int nst, nt, nn, ns, nc, lim;
      bit nq, nsrc, wk, ok, exp_done;
      wk = (m_st >= 4);
      ok = m_allok(m_n, reg_ok);
      nc = m_c; nq = m_q;
      if (!ok) begin nc = 0; nq = 0; end
      else if (!m_q && tick_ms) begin
        if (m_c == PG - 1) nq = 1; else nc = m_c + 1;
      end
      nn = m_n; ns = m_s;
      if (!wk) begin nn = 0; ns = 0; end
      else if (m_n == 0) begin nn = 1; ns = 0; end
      else if (m_n < NR && tick_ms) begin
        if (m_s == STP - 1) begin nn = m_n + 1; ns = 0; end else ns = m_s + 1;
      end
      lim = lim_of(m_st, m_src);
      exp_done = (lim > 0) && tick_ms && (m_t == lim - 1);
      nst = m_st; nsrc = m_src;
      if (m_boot) nst = bat_ok ? 0 : 2;
      else case (m_st)
        0, 1: begin
          if (pbtn && !m_pb) nst = 4;
          else if (bat_ok && ext_pwr && !m_pe) begin nst = 3; nsrc = 0; end
          else if (bat_ok && host_on && !m_ph) begin nst = 3; nsrc = 1; end
        end
        2: if (exp_done) nst = 1;
        3: if (exp_done) nst = 5;
        4, 5: if (exp_done) nst = host_on ? 6 : 0;
        default: if (!host_on) nst = 0;
      endcase
      if (nst != m_st) nt = 0;
      else if (lim > 0 && tick_ms) nt = m_t + 1;
      else nt = m_t;
      m_st = nst; m_t = nt; m_src = nsrc; m_boot = 0;
      m_n = nn; m_s = ns; m_c = nc; m_q = nq;
      m_pe = ext_pwr; m_ph = host_on; m_pb = pbtn;
    end
  end

  always begin
    @(negedge clk);
    #5;
    if (rst_n && !done) begin
      chk_eq("R2/R3/R4/R5/R6/R7 state", state_code, m_st);
      chk_eq("R8 wake", wake_rel, m_st >= 4);
      chk_eq("R8 aux", aux_perm, m_st >= 4);
      chk_eq("R9/R10 reg_en", reg_en, en_mask(m_n));
      chk_eq("R11 pgood", pgood, m_q && m_allok(m_n, reg_ok));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic steps(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4711));
    tick_ms = 1'b1;
    steps(3);
    rst_n = 1'b1;
    // R1: reset state, no battery
    chk_eq("R1 state", state_code, 0);
    chk_eq("R1 wake", wake_rel, 0);
    chk_eq("R1 reg_en", reg_en, 0);
    chk_eq("R1 pgood", pgood, 0);
    steps(1);
    chk_eq("R1 pdn2", state_code, 2);
    begin
      int n = 0;
      while (state_code == 3'd2 && n < 100) begin steps(1); n++; end
      chk_eq("R2 pdn2 length", n, PDN);
      chk_eq("R2 hard reset", state_code, 1);
    end
    ext_pwr = 1; host_on = 1;
    steps(3);
    chk_eq("R2 ignore without battery", state_code, 1);
    ext_pwr = 0; host_on = 0;
    steps(1);
    pbtn = 1;
    steps(1);
    pbtn = 0;
    chk_eq("R5 button", state_code, 4);
    chk_eq("R8 aux", aux_perm, 1);
    chk_eq("R9 none yet", reg_en, 0);
    steps(1); chk_eq("R9 first", reg_en, 1);
    steps(2); chk_eq("R9 second", reg_en, 3);
    steps(2); chk_eq("R9 third", reg_en, 7);
    host_on = 1;
    steps(34); chk_eq("R6 window open", state_code, 4);
    steps(1);  chk_eq("R6 on", state_code, 6);
    chk_eq("R11 qualified", pgood, 1);
    reg_ok = 3'b101;
    #1 chk_eq("R11 drop same cycle", pgood, 0);
    steps(1);
    reg_ok = '1;
    host_on = 0;
    steps(1); chk_eq("R7 host off", state_code, 0);
    steps(1); chk_eq("R10 all off", reg_en, 0);
    bat_ok = 1;
    steps(2);
    ext_pwr = 1; pbtn = 1;
    steps(1);
    pbtn = 0;
    chk_eq("R5 button beats supply", state_code, 4);
    steps(39); chk_eq("R6 window open", state_code, 4);
    steps(1);  chk_eq("R6 no host", state_code, 0);
    steps(1);  chk_eq("R10 all off", reg_en, 0);
    ext_pwr = 0;
    steps(2);
    ext_pwr = 1;
    steps(1); chk_eq("R3 settling", state_code, 3);
    steps(5); chk_eq("R3 still settling", state_code, 3);
    steps(1); chk_eq("R3 powered", state_code, 5);
    steps(40); chk_eq("R6 no host", state_code, 0);
    host_on = 1;
    steps(1); chk_eq("R4 settling", state_code, 3);
    steps(3); chk_eq("R4 still settling", state_code, 3);
    steps(1); chk_eq("R4 powered", state_code, 5);
    steps(40); chk_eq("R6 on", state_code, 6);
    host_on = 0;
    steps(1); chk_eq("R7 host off", state_code, 0);
    // random phase
    for (int i = 0; i < 30000; i++) begin
      tick_ms = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 39) == 0) ext_pwr = ~ext_pwr;
      if ($urandom_range(0, 29) == 0) host_on = ~host_on;
      pbtn = ($urandom_range(0, 199) == 0);
      if ($urandom_range(0, 299) == 0) bat_ok = ~bat_ok;
      for (int b = 0; b < NR; b++) reg_ok[b] = ($urandom_range(0, 29) != 0);
      steps(1);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule